// File: doc/BRIEF.md
# Banked Host Register File with Command Decode

This block is the host-facing register file of a network controller. A host bus slave reaches 48 byte-wide register locations through a window of only 16 offsets. The locations are grouped into three banks, and only one bank is visible at a time. Offset 0 is not banked. It is a single command register that every bank shares. A write to it does two things in the same access: it issues a command to the rest of the chip, and it may move the window to another bank.

The block keeps a sticky interrupt status register and its mask register, and it drives one interrupt line toward the host. It also holds two configuration values for the streaming-overlap features: a transmit-overlap enable bit and a receive-overlap level byte. A nonzero receive level turns the receive feature on. The block does not carry out the commands. It only hands out a one-clock strobe with the op code and the abort flag.

Top module: `bank_regfile`

## Requirements
- R1: After reset, bank 0 is selected, all status bits are 0, all mask bits are 1, the receive-overlap level is 00h, the transmit-overlap enable is 0, and `irq` and `cmd_valid` are low.
- R2: Offset 0 reaches the command register whichever bank is selected. When read, it returns the current bank number in bits 7:6 and 0 in bits 5:0.
- R3: A write to offset 0 with bits 7:6 equal to 0, 1 or 2 selects that bank for every later access. The value 3 is reserved, and a write carrying it leaves the bank unchanged.
- R4: Every write to offset 0 makes `cmd_valid` high for exactly the one clock that follows the write. During that clock, `cmd_opcode` equals the written bits 4:0 and `cmd_abort` equals the written bit 5.
- R5: Status sits at bank 0, offset 1, with bit 0 for receive-stopped, bit 1 for frame-received, bit 2 for transmit-done and bit 3 for command-done. Each bit is set by a pulse on the matching `evt_set` line and stays set. Writing 1 to a bit clears it. If an event and a clear hit the same bit in the same cycle, the bit stays set.
- R6: The mask sits at bank 0, offset 3, in bits 3:0, and a 1 disables the matching source. `irq` is high exactly when some status bit is set and its mask bit is 0.
- R7: Bank 2, offset 1, bit 0 is the transmit-overlap enable and drives `tx_overlap_en`.
- R8: Bank 1, offset 7, is the 8-bit receive-overlap level and drives `rx_overlap_level`. `rx_overlap_en` is high exactly when that level is not 00h.
- R9: Reserved bits and unused offsets read as 0 and ignore writes. `bus_rdata` is 0 whenever `bus_rd` is low.
- R10: A write to a banked offset reaches only the register of the currently selected bank. For example, a write to offset 1 while bank 1 is selected changes neither the status register nor the transmit-overlap enable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 4 | Register offset within the window |
| bus_wdata | input | 8 | Write data |
| bus_wr | input | 1 | Write strobe, one access per high cycle |
| bus_rd | input | 1 | Read strobe |
| bus_rdata | output | 8 | Read data, combinational from offset and bank |
| evt_set | input | 4 | Interrupt source pulses, in status bit order |
| irq | output | 1 | Interrupt request to the host |
| cmd_valid | output | 1 | One-clock command strobe |
| cmd_opcode | output | 5 | Op code of the issued command |
| cmd_abort | output | 1 | Abort flag of the issued command |
| tx_overlap_en | output | 1 | Transmit-overlap enable |
| rx_overlap_level | output | 8 | Receive-overlap level |
| rx_overlap_en | output | 1 | Receive-overlap active (level nonzero) |

## Verification
Random writes go to every offset, with every pointer value including the reserved one. Random read-backs are mixed in, so a bank decode that uses the wrong bank, or that fails to share offset 0, shows up as a wrong register value. Random event bursts overlap with write-1-clear writes and with mask writes, which separates set-wins ordering, wrong bit order and wrong mask polarity. Directed cases cover three situations: the reserved pointer, an event and a clear on the same bit in the same cycle, and receive levels of 00h and 01h. The last case tests the nonzero detection at its boundary.

// File: rtl/regfile_pkg.sv
package regfile_pkg;
    localparam int DATA_W   = 8;
    localparam int ADDR_W   = 4;
    localparam int IRQ_N    = 4;
    localparam int OPCODE_W = 5;

    localparam logic [ADDR_W-1:0] OFF_CMD    = 4'd0;
    localparam logic [ADDR_W-1:0] OFF_STATUS = 4'd1;
    localparam logic [ADDR_W-1:0] OFF_MASK   = 4'd3;
    localparam logic [ADDR_W-1:0] OFF_TXOV   = 4'd1;
    localparam logic [ADDR_W-1:0] OFF_RXOV   = 4'd7;

    typedef enum logic [1:0] {
        BANK_0    = 2'd0,
        BANK_1    = 2'd1,
        BANK_2    = 2'd2,
        BANK_RSVD = 2'd3
    } bank_e;

    typedef struct packed {
        logic                valid;
        logic                abort;
        logic [OPCODE_W-1:0] opcode;
    } cmd_t;

    function automatic logic bank_hit(input bank_e cur, input logic [ADDR_W-1:0] addr,
                                      input bank_e want, input logic [ADDR_W-1:0] off);
        return (cur == want) && (addr == off);
    endfunction
endpackage

// File: rtl/cmd_bank_ctrl.sv
module cmd_bank_ctrl
    import regfile_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              cmd_wr,
    input  logic [DATA_W-1:0] wdata,
    output bank_e             bank,
    output cmd_t              cmd
);
    bank_e ptr_field;
    assign ptr_field = bank_e'(wdata[DATA_W-1 -: 2]);

    always_ff @(posedge clk) begin
        if (rst) begin
            bank <= BANK_0;
            cmd  <= '0;
        end else begin
            cmd.valid  <= cmd_wr;
            cmd.abort  <= cmd_wr ? wdata[OPCODE_W] : 1'b0;
            cmd.opcode <= cmd_wr ? wdata[OPCODE_W-1:0] : '0;
            if (cmd_wr && ptr_field != BANK_RSVD)
                bank <= ptr_field;
        end
    end
endmodule

// File: rtl/irq_ctrl.sv
module irq_ctrl #(
    parameter int N = 4
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] evt,
    input  logic         clr_wr,
    input  logic         mask_wr,
    input  logic [N-1:0] wdata,
    output logic [N-1:0] status,
    output logic [N-1:0] mask,
    output logic         irq
);
    logic [N-1:0] pending;

    for (genvar i = 0; i < N; i++) begin : g_src
        always_ff @(posedge clk) begin
            if (rst) begin
                status[i] <= 1'b0;
                mask[i]   <= 1'b1;
            end else begin
                // a new event wins over a simultaneous clear
                status[i] <= evt[i] | (status[i] & ~(clr_wr & wdata[i]));
                if (mask_wr)
                    mask[i] <= wdata[i];
            end
        end
        assign pending[i] = status[i] & ~mask[i];
    end

    assign irq = |pending;
endmodule

// File: rtl/cfg_ctrl.sv
module cfg_ctrl #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         rx_wr,
    input  logic         tx_wr,
    input  logic [W-1:0] wdata,
    output logic [W-1:0] rx_level,
    output logic         tx_en,
    output logic         rx_en
);
    always_ff @(posedge clk) begin
        if (rst) begin
            rx_level <= '0;
            tx_en    <= 1'b0;
        end else begin
            if (rx_wr) rx_level <= wdata;
            if (tx_wr) tx_en    <= wdata[0];
        end
    end

    assign rx_en = |rx_level;
endmodule

// File: rtl/bank_regfile.sv
module bank_regfile
    import regfile_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic [ADDR_W-1:0]   bus_addr,
    input  logic [DATA_W-1:0]   bus_wdata,
    input  logic                bus_wr,
    input  logic                bus_rd,
    output logic [DATA_W-1:0]   bus_rdata,
    input  logic [IRQ_N-1:0]    evt_set,
    output logic                irq,
    output logic                cmd_valid,
    output logic [OPCODE_W-1:0] cmd_opcode,
    output logic                cmd_abort,
    output logic                tx_overlap_en,
    output logic [DATA_W-1:0]   rx_overlap_level,
    output logic                rx_overlap_en
);
    bank_e            cur_bank;
    cmd_t             cmd;
    logic [IRQ_N-1:0] status;
    logic [IRQ_N-1:0] mask;
    logic             wr_cmd, wr_status, wr_mask, wr_rx, wr_tx;

    assign wr_cmd    = bus_wr && (bus_addr == OFF_CMD);
    assign wr_status = bus_wr && bank_hit(cur_bank, bus_addr, BANK_0, OFF_STATUS);
    assign wr_mask   = bus_wr && bank_hit(cur_bank, bus_addr, BANK_0, OFF_MASK);
    assign wr_rx     = bus_wr && bank_hit(cur_bank, bus_addr, BANK_1, OFF_RXOV);
    assign wr_tx     = bus_wr && bank_hit(cur_bank, bus_addr, BANK_2, OFF_TXOV);

    cmd_bank_ctrl i_cmd (
        .clk   (clk),
        .rst   (rst),
        .cmd_wr(wr_cmd),
        .wdata (bus_wdata),
        .bank  (cur_bank),
        .cmd   (cmd)
    );

    irq_ctrl #(.N(IRQ_N)) i_irq (
        .clk    (clk),
        .rst    (rst),
        .evt    (evt_set),
        .clr_wr (wr_status),
        .mask_wr(wr_mask),
        .wdata  (bus_wdata[IRQ_N-1:0]),
        .status (status),
        .mask   (mask),
        .irq    (irq)
    );

    cfg_ctrl #(.W(DATA_W)) i_cfg (
        .clk     (clk),
        .rst     (rst),
        .rx_wr   (wr_rx),
        .tx_wr   (wr_tx),
        .wdata   (bus_wdata),
        .rx_level(rx_overlap_level),
        .tx_en   (tx_overlap_en),
        .rx_en   (rx_overlap_en)
    );

    assign cmd_valid  = cmd.valid;
    assign cmd_opcode = cmd.opcode;
    assign cmd_abort  = cmd.abort;

    logic [DATA_W-1:0] rd_mux;
    always_comb begin
        rd_mux = '0;
        if (bus_addr == OFF_CMD)
            rd_mux[DATA_W-1 -: 2] = cur_bank;
        else if (bank_hit(cur_bank, bus_addr, BANK_0, OFF_STATUS))
            rd_mux[IRQ_N-1:0] = status;
        else if (bank_hit(cur_bank, bus_addr, BANK_0, OFF_MASK))
            rd_mux[IRQ_N-1:0] = mask;
        else if (bank_hit(cur_bank, bus_addr, BANK_1, OFF_RXOV))
            rd_mux = rx_overlap_level;
        else if (bank_hit(cur_bank, bus_addr, BANK_2, OFF_TXOV))
            rd_mux[0] = tx_overlap_en;
    end

    assign bus_rdata = bus_rd ? rd_mux : '0;
endmodule

// File: rtl/regfile_checker.sv
module regfile_checker
    import regfile_pkg::*;
(
    input logic                clk,
    input logic                rst,
    input logic [ADDR_W-1:0]   bus_addr,
    input logic [1:0]          wr_ptr,
    input logic                bus_wr,
    input logic [IRQ_N-1:0]    evt_set,
    input logic                irq,
    input logic                cmd_valid,
    input logic [1:0]          cur_bank,
    input logic [IRQ_N-1:0]    status,
    input logic                tx_overlap_en,
    input logic [DATA_W-1:0]   rx_overlap_level
);
    assert_reset_state_R1: assert property (@(posedge clk)
        rst |=> (cur_bank == 2'd0 && !cmd_valid && !irq && status == '0));

    assert_rsvd_ptr_keeps_bank_R3: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && bus_addr == OFF_CMD && wr_ptr == 2'd3) |=> $stable(cur_bank));

    assert_bank_only_moves_on_cmd_R3: assert property (@(posedge clk) disable iff (rst)
        !$stable(cur_bank) |-> $past(bus_wr && bus_addr == OFF_CMD));

    assert_cmd_follows_write_R4: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && bus_addr == OFF_CMD) |=> cmd_valid);

    assert_cmd_needs_write_R4: assert property (@(posedge clk) disable iff (rst)
        cmd_valid |-> $past(bus_wr && bus_addr == OFF_CMD));

    assert_status_clears_by_write_R5: assert property (@(posedge clk) disable iff (rst)
        (|($past(status) & ~status)) |-> $past(bus_wr && cur_bank == 2'd0 && bus_addr == OFF_STATUS));

    assert_irq_rise_cause_R6: assert property (@(posedge clk) disable iff (rst)
        $rose(irq) |-> $past(evt_set != '0 || (bus_wr && bus_addr == OFF_MASK)));

    assert_tx_cfg_write_only_R7: assert property (@(posedge clk) disable iff (rst)
        !$stable(tx_overlap_en) |-> $past(bus_wr && cur_bank == 2'd2 && bus_addr == OFF_TXOV));

    assert_rx_cfg_write_only_R8: assert property (@(posedge clk) disable iff (rst)
        !$stable(rx_overlap_level) |-> $past(bus_wr && cur_bank == 2'd1 && bus_addr == OFF_RXOV));
endmodule

bind bank_regfile regfile_checker i_checker (
    .clk             (clk),
    .rst             (rst),
    .bus_addr        (bus_addr),
    .wr_ptr          (bus_wdata[7:6]),
    .bus_wr          (bus_wr),
    .evt_set         (evt_set),
    .irq             (irq),
    .cmd_valid       (cmd_valid),
    .cur_bank        (cur_bank),
    .status          (status),
    .tx_overlap_en   (tx_overlap_en),
    .rx_overlap_level(rx_overlap_level)
);

// File: tb/test_bank_regfile.sv
module test_bank_regfile;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [3:0] bus_addr = '0;
    logic [7:0] bus_wdata = '0;
    logic       bus_wr = 1'b0;
    logic       bus_rd = 1'b0;
    logic [7:0] bus_rdata;
    logic [3:0] evt_set = '0;
    logic       irq, cmd_valid, cmd_abort, tx_overlap_en, rx_overlap_en;
    logic [4:0] cmd_opcode;
    logic [7:0] rx_overlap_level;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    // bench model
    logic [1:0] m_bank = 2'd0;
    logic [3:0] m_stat = 4'h0;
    logic [3:0] m_mask = 4'hF;
    logic [7:0] m_rx = 8'h00;
    logic       m_tx = 1'b0;

    always #2.5 clk = ~clk;

    bank_regfile i_bank_regfile (
        .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_rdata(bus_rdata), .evt_set(evt_set),
        .irq(irq), .cmd_valid(cmd_valid), .cmd_opcode(cmd_opcode), .cmd_abort(cmd_abort),
        .tx_overlap_en(tx_overlap_en), .rx_overlap_level(rx_overlap_level),
        .rx_overlap_en(rx_overlap_en)
    );

    task automatic check(input string req, input string what, input logic [31:0] act,
                         input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    function automatic logic [7:0] exp_read(input logic [3:0] a);
        if (a == 4'd0) return {m_bank, 6'b0};
        if (m_bank == 2'd0 && a == 4'd1) return {4'b0, m_stat};
        if (m_bank == 2'd0 && a == 4'd3) return {4'b0, m_mask};
        if (m_bank == 2'd1 && a == 4'd7) return m_rx;
        if (m_bank == 2'd2 && a == 4'd1) return {7'b0, m_tx};
        return 8'h00;
    endfunction

    task automatic model_apply(input bit w, input logic [3:0] a, input logic [7:0] d,
                               input logic [3:0] e);
        logic [3:0] clr = '0;
        if (w) begin
            if (m_bank == 2'd0 && a == 4'd1) clr = d[3:0];
            if (m_bank == 2'd0 && a == 4'd3) m_mask = d[3:0];
            if (m_bank == 2'd1 && a == 4'd7) m_rx = d;
            if (m_bank == 2'd2 && a == 4'd1) m_tx = d[0];
            if (a == 4'd0 && d[7:6] != 2'd3) m_bank = d[7:6];
        end
        m_stat = (m_stat & ~clr) | e;
    endtask

    task automatic rd_check(input logic [3:0] a, input string req);
        bus_rd = 1'b1;
        bus_addr = a;
        #0.5;
        check(req, "rdata", bus_rdata, exp_read(a));
        bus_rd = 1'b0;
        #0.5;
        check("R9", "rdata idle", bus_rdata, 8'h00);
    endtask

    task automatic step(input bit w, input logic [3:0] a, input logic [7:0] d,
                        input logic [3:0] e, input logic [3:0] ra, input string req);
        bus_wr = w; bus_addr = a; bus_wdata = d; evt_set = e;
        @(posedge clk);
        #1;
        bus_wr = 1'b0; evt_set = '0;
        model_apply(w, a, d, e);
        check("R4", "cmd_valid", cmd_valid, (w && a == 4'd0));
        if (w && a == 4'd0) begin
            check("R4", "cmd_opcode", cmd_opcode, d[4:0]);
            check("R4", "cmd_abort", cmd_abort, d[5]);
        end
        check("R6", "irq", irq, |(m_stat & ~m_mask));
        check("R7", "tx_overlap_en", tx_overlap_en, m_tx);
        check("R8", "rx_overlap_level", rx_overlap_level, m_rx);
        check("R8", "rx_overlap_en", rx_overlap_en, (m_rx != 8'h00));
        rd_check(ra, req);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd1234));
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;
        // R1: reset state
        check("R1", "irq", irq, 1'b0);
        check("R1", "cmd_valid", cmd_valid, 1'b0);
        check("R1", "tx_overlap_en", tx_overlap_en, 1'b0);
        check("R1", "rx_overlap_level", rx_overlap_level, 8'h00);
        rd_check(4'd0, "R1");
        rd_check(4'd1, "R1");
        rd_check(4'd3, "R1");

        // R2, R3: select each bank, offset 0 reachable from each
        step(1, 4'd0, 8'h41, 4'h0, 4'd0, "R2");
        step(1, 4'd0, 8'h82, 4'h0, 4'd0, "R2");
        // R3: reserved pointer keeps bank 2
        step(1, 4'd0, 8'hFF, 4'h0, 4'd0, "R3");
        check("R3", "bank after rsvd", bus_rdata, 8'h00);
        // R7 set and read back in bank 2
        step(1, 4'd1, 8'hFF, 4'h0, 4'd1, "R7");
        // R10: back to bank 0, mask open, raise status, then write offset 1 in bank 1
        step(1, 4'd0, 8'h00, 4'h0, 4'd1, "R10");
        step(1, 4'd3, 8'h00, 4'hA, 4'd1, "R6");
        step(1, 4'd0, 8'h40, 4'h0, 4'd1, "R10");
        step(1, 4'd1, 8'hFF, 4'h0, 4'd1, "R10");
        step(1, 4'd0, 8'h00, 4'h0, 4'd1, "R10");
        // R5: clear and set same bit in the same cycle, set wins
        step(1, 4'd1, 8'h0F, 4'h2, 4'd1, "R5");
        // R9: reserved offset in bank 0
        step(1, 4'd5, 8'hFF, 4'h0, 4'd5, "R9");
        // R8: level boundary 00h / 01h
        step(1, 4'd0, 8'h40, 4'h0, 4'd7, "R8");
        step(1, 4'd7, 8'h01, 4'h0, 4'd7, "R8");
        step(1, 4'd7, 8'h00, 4'h0, 4'd7, "R8");

        // random traffic
        for (int i = 0; i < 4000; i++) begin
            bit         w  = ($urandom % 3) != 0;
            logic [3:0] a;
            logic [3:0] e  = (($urandom % 4) == 0) ? 4'($urandom) : 4'h0;
            logic [3:0] ra = 4'($urandom);
            case ($urandom % 4)
                0: a = 4'd0;
                1: a = 4'd1;
                2: a = (($urandom % 2) != 0) ? 4'd3 : 4'd7;
                default: a = 4'($urandom);
            endcase
            step(w, a, 8'($urandom), e, ra, "R5");
        end

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule